// File: doc/BRIEF.md
# Multi-Mode Reset Sequencer

This block steps a chip through its internal reset after a reset request arrives. Four request inputs select among five sequence variants. A destructive request gives a long sequence, with a self-test stage when self-test is enabled. An external request gives the same long sequence. A functional-long request skips the stage before self-test. A functional-short request runs only the first and the last timed stage, and it never pulls the board-level reset line low.

Each timed stage lasts for a parameterised number of clock cycles. Small defaults keep simulation short, and real millisecond values are obtained by raising the parameters. The reset line is open-drain: the block can only pull it low, and a pull-up on the board raises it. When the timed stages are done, the block lets go of the line. It then waits for the line to read high through a synchroniser and a glitch filter, because another device may still be holding it low. After that it enters run mode, where instruction fetch may begin.

Top module: `reset_sequencer`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, the outputs show phase 0 with `pinDriveLow`=1, `runMode`=0, `bistStart`=0 and `bistErr`=0. The block then runs a destructive sequence without self-test.
- R2: Phase codes are: 0, 1, 2 and 3 for the timed stages, 4 for self-test, 5 for release-wait and 6 for run. A destructive or external sequence visits 0, 1, 2, then 4 if self-test was enabled, then 3 and 5. Phases 0 to 3 last PH0_CYC, PH1_CYC, PH2_CYC and PH3_CYC cycles.
- R3: `bistEn` is sampled when a destructive or external request is accepted. In phase 4, `bistStart` is high for exactly the first cycle. A `bistDone` seen in the Nth cycle of phase 4 moves the block to phase 3 on the next edge.
- R4: If `bistDone` does not arrive, phase 4 lasts BIST_TO cycles and then sets `bistErr`. `bistErr` stays set until the next accepted request clears it, and that request's first cycle already shows it cleared. A self-test that ends on `bistDone` leaves `bistErr` at 0.
- R5: A functional-long sequence goes from phase 0 to phase 1 and then to phase 3. It never shows phase 2 or phase 4.
- R6: A functional-short sequence goes from phase 0 straight to phase 3. It holds `pinDriveLow` at 0 throughout.
- R7: For every kind except functional-short, `pinDriveLow` is 1 in phases 0 to 4. In phases 5 and 6 it is 0 for every kind.
- R8: Phase 5 ends only after the line has read high on FILT_CYC consecutive synchronised samples. The run phase is shown on the (FILT_CYC+3)th edge after the line rises. A high pulse shorter than FILT_CYC cycles is ignored, and any time the line is held low stretches phase 5.
- R9: `runMode` is 1 exactly in phase 6. It stays 1 until a request arrives.
- R10: Requests that arrive in the same cycle are ranked destructive, then external, then functional-long, then functional-short. Only the highest-ranked one is used.
- R11: In run mode any request starts a sequence at phase 0 on the next edge. During a sequence, only a request that ranks strictly higher than the running kind restarts it at phase 0. Requests of equal or lower rank have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| trigDestr | input | 1 | Destructive reset request |
| trigExt | input | 1 | External reset request |
| trigFuncLong | input | 1 | Functional-long reset request |
| trigFuncShort | input | 1 | Functional-short reset request |
| bistEn | input | 1 | Self-test enable, sampled when a request is accepted |
| bistDone | input | 1 | Self-test completion flag |
| pinIn | input | 1 | Raw level read back from the reset line |
| pinDriveLow | output | 1 | Enable that pulls the reset line low |
| phase | output | 3 | Current phase code (see R2) |
| bistStart | output | 1 | One-cycle self-test start pulse |
| runMode | output | 1 | Run mode; instruction fetch may begin |
| bistErr | output | 1 | Self-test timed out |

## Verification
The bound checker watches invariants that hold on every cycle. `bistStart` is a single-cycle pulse that only occurs in phase 4. An error can only appear as phase 4 ends. Run mode can only be entered from release-wait. The line is never driven in release-wait or run mode, and run mode persists while no request arrives. Other behaviour needs scenarios in the bench: the stage lengths, the path each kind takes, the ranking of simultaneous or overlapping requests, the timeout and its clearing, rejection of a short high glitch, and the exact release latency. The bench's cycle model covers these, as do targeted checks.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    PH_0    = 3'd0,
    PH_1    = 3'd1,
    PH_2    = 3'd2,
    PH_3    = 3'd3,
    PH_BIST = 3'd4,
    PH_REL  = 3'd5,
    PH_RUN  = 3'd6
  } phase_e;

  // Encoding order is the request rank: larger value wins.
  typedef enum logic [1:0] {
    K_FSHORT = 2'd0,
    K_FLONG  = 2'd1,
    K_EXT    = 2'd2,
    K_DESTR  = 2'd3
  } kind_e;

  typedef struct packed {
    logic   cntRestart;
    phase_e cntSel;
  } dpStrobe_t;

  function automatic int unsigned maxOf(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rstseq_dp.sv
module rstseq_dp
  import rstseq_pkg::*;
#(
  parameter int unsigned PH0_CYC  = 4,
  parameter int unsigned PH1_CYC  = 6,
  parameter int unsigned PH2_CYC  = 8,
  parameter int unsigned PH3_CYC  = 3,
  parameter int unsigned BIST_TO  = 20,
  parameter int unsigned FILT_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic       pinIn,
  output logic       cntExpired,
  output logic       pinHigh
);

  localparam int unsigned MAX_LEN =
    maxOf(maxOf(maxOf(PH0_CYC, PH1_CYC), maxOf(PH2_CYC, PH3_CYC)), BIST_TO);
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_comb begin
    case (strobe.cntSel)
      PH_0:    limit = CNT_W'(PH0_CYC);
      PH_1:    limit = CNT_W'(PH1_CYC);
      PH_2:    limit = CNT_W'(PH2_CYC);
      PH_3:    limit = CNT_W'(PH3_CYC);
      PH_BIST: limit = CNT_W'(BIST_TO);
      default: limit = '0;
    endcase
  end

  assign cntExpired = (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (strobe.cntRestart) cnt <= '0;
    else                       cnt <= cnt + CNT_W'(1);
  end

  logic sync1, sync2;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= pinIn;
      sync2 <= sync1;
    end
  end

  generate
    if (FILT_CYC == 0) begin : g_noFilt
      assign pinHigh = sync2;
    end else begin : g_filt
      localparam int unsigned FW = $clog2(FILT_CYC + 1);
      logic [FW-1:0] stable;
      logic          level;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stable <= '0;
          level  <= 1'b0;
        end else if (sync2 == level) begin
          stable <= '0;
        end else if (stable == FW'(FILT_CYC - 1)) begin
          stable <= '0;
          level  <= sync2;
        end else begin
          stable <= stable + FW'(1);
        end
      end
      assign pinHigh = level;
    end
  endgenerate

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      trigDestr,
  input  logic      trigExt,
  input  logic      trigFuncLong,
  input  logic      trigFuncShort,
  input  logic      bistEn,
  input  logic      bistDone,
  input  logic      cntExpired,
  input  logic      pinHigh,
  output dpStrobe_t strobe,
  output phase_e    phase,
  output logic      pinDriveLow,
  output logic      bistStart,
  output logic      runMode,
  output logic      bistErr
);

  phase_e state, nextState;
  kind_e  kind, reqKind;
  logic   withBist, fresh, anyReq, newSeq, errSet;

  always_comb begin
    anyReq = trigDestr | trigExt | trigFuncLong | trigFuncShort;
    if (trigDestr)         reqKind = K_DESTR;
    else if (trigExt)      reqKind = K_EXT;
    else if (trigFuncLong) reqKind = K_FLONG;
    else                   reqKind = K_FSHORT;
    newSeq = anyReq && ((state == PH_RUN) || (reqKind > kind));
  end

  always_comb begin
    nextState = state;
    errSet    = 1'b0;
    case (state)
      PH_0:    if (cntExpired) nextState = (kind == K_FSHORT) ? PH_3 : PH_1;
      PH_1:    if (cntExpired) nextState = (kind == K_FLONG) ? PH_3 : PH_2;
      PH_2:    if (cntExpired) nextState = withBist ? PH_BIST : PH_3;
      PH_BIST: begin
        if (bistDone || cntExpired) nextState = PH_3;
        errSet = cntExpired && !bistDone;
      end
      PH_3:    if (cntExpired) nextState = PH_REL;
      PH_REL:  if (pinHigh) nextState = PH_RUN;
      default: nextState = state;
    endcase
    if (newSeq) nextState = PH_0;
  end

  always_comb begin
    strobe.cntRestart = newSeq || (nextState != state);
    strobe.cntSel     = state;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PH_0;
      kind     <= K_DESTR;
      withBist <= 1'b0;
      fresh    <= 1'b1;
      bistErr  <= 1'b0;
    end else begin
      state <= nextState;
      fresh <= strobe.cntRestart;
      if (newSeq) begin
        kind     <= reqKind;
        withBist <= bistEn && ((reqKind == K_DESTR) || (reqKind == K_EXT));
        bistErr  <= 1'b0;
      end else if (errSet) begin
        bistErr  <= 1'b1;
      end
    end
  end

  assign phase       = state;
  assign runMode     = (state == PH_RUN);
  assign bistStart   = (state == PH_BIST) && fresh;
  assign pinDriveLow = (kind != K_FSHORT) && (state != PH_REL) && (state != PH_RUN);

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int unsigned PH0_CYC  = 4,
  parameter int unsigned PH1_CYC  = 6,
  parameter int unsigned PH2_CYC  = 8,
  parameter int unsigned PH3_CYC  = 3,
  parameter int unsigned BIST_TO  = 20,
  parameter int unsigned FILT_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigDestr,
  input  logic       trigExt,
  input  logic       trigFuncLong,
  input  logic       trigFuncShort,
  input  logic       bistEn,
  input  logic       bistDone,
  input  logic       pinIn,
  output logic       pinDriveLow,
  output logic [2:0] phase,
  output logic       bistStart,
  output logic       runMode,
  output logic       bistErr
);

  dpStrobe_t strobe;
  phase_e    phaseInt;
  logic      cntExpired, pinHigh;

  rstseq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .trigDestr(trigDestr), .trigExt(trigExt),
    .trigFuncLong(trigFuncLong), .trigFuncShort(trigFuncShort),
    .bistEn(bistEn), .bistDone(bistDone),
    .cntExpired(cntExpired), .pinHigh(pinHigh),
    .strobe(strobe), .phase(phaseInt),
    .pinDriveLow(pinDriveLow), .bistStart(bistStart),
    .runMode(runMode), .bistErr(bistErr)
  );

  rstseq_dp #(
    .PH0_CYC(PH0_CYC), .PH1_CYC(PH1_CYC), .PH2_CYC(PH2_CYC),
    .PH3_CYC(PH3_CYC), .BIST_TO(BIST_TO), .FILT_CYC(FILT_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pinIn(pinIn),
    .cntExpired(cntExpired), .pinHigh(pinHigh)
  );

  assign phase = phaseInt;

endmodule

// File: rtl/reset_sequencer_chk.sv
module reset_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       trigDestr,
  input logic       trigExt,
  input logic       trigFuncLong,
  input logic       trigFuncShort,
  input logic       pinDriveLow,
  input logic [2:0] phase,
  input logic       bistStart,
  input logic       runMode,
  input logic       bistErr
);

  logic anyReq;
  assign anyReq = trigDestr | trigExt | trigFuncLong | trigFuncShort;

  AST_BIST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    bistStart |=> !bistStart); // R3

  AST_BIST_START_IN_TEST: assert property (@(posedge clk) disable iff (!rstN)
    bistStart |-> (phase == 3'd4)); // R3

  AST_ERR_FROM_TEST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bistErr) |-> ($past(phase) == 3'd4) && (phase == 3'd3)); // R4

  AST_RUN_FROM_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runMode) |-> ($past(phase) == 3'd5)); // R8

  AST_RUN_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    runMode |-> !pinDriveLow); // R7

  AST_RELEASE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd5) |-> !pinDriveLow); // R7

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (runMode && !anyReq) |=> runMode); // R9

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (runMode && anyReq) |=> (phase == 3'd0)); // R11

endmodule

bind reset_sequencer reset_sequencer_chk chk_i (
  .clk(clk), .rstN(rstN),
  .trigDestr(trigDestr), .trigExt(trigExt),
  .trigFuncLong(trigFuncLong), .trigFuncShort(trigFuncShort),
  .pinDriveLow(pinDriveLow), .phase(phase), .bistStart(bistStart),
  .runMode(runMode), .bistErr(bistErr)
);

// File: tb/reset_sequencer_tb_top.sv
`timescale 1ns/1ps
module reset_sequencer_tb_top;

  localparam int P0 = 4, P1 = 6, P2 = 8, P3 = 3, BT = 20, FC = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic trigDestr = 0, trigExt = 0, trigFuncLong = 0, trigFuncShort = 0;
  logic bistEn = 0, bistDone = 0, extHold = 0;
  logic pinIn, pinDriveLow, bistStart, runMode, bistErr;
  logic [2:0] phase;

  always #2 clk = ~clk;

  assign pinIn = !(pinDriveLow || extHold);

  reset_sequencer #(.PH0_CYC(P0), .PH1_CYC(P1), .PH2_CYC(P2), .PH3_CYC(P3),
                    .BIST_TO(BT), .FILT_CYC(FC)) dut_i (
    .clk(clk), .rstN(rstN), .trigDestr(trigDestr), .trigExt(trigExt),
    .trigFuncLong(trigFuncLong), .trigFuncShort(trigFuncShort),
    .bistEn(bistEn), .bistDone(bistDone), .pinIn(pinIn),
    .pinDriveLow(pinDriveLow), .phase(phase), .bistStart(bistStart),
    .runMode(runMode), .bistErr(bistErr));

  int total = 0, bad = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mSt = 0, mKind = 3, mBist = 0, mCnt = 0, mErr = 0, mFresh = 1;
  int s1 = 0, s2 = 0, filt = 0, streak = 0;

  function automatic int plen(int st);
    case (st)
      0: return P0;
      1: return P1;
      2: return P2;
      3: return P3;
      4: return BT;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin : model
    int req, nx;
    bit newS, expd, restart;
    if (!rstN) begin
      mSt = 0; mKind = 3; mBist = 0; mCnt = 0; mErr = 0; mFresh = 1;
      s1 = 0; s2 = 0; filt = 0; streak = 0;
    end else begin
      req = trigDestr ? 3 : trigExt ? 2 : trigFuncLong ? 1 : trigFuncShort ? 0 : -1;
      newS = (req >= 0) && (mSt == 6 || req > mKind);
      expd = (mCnt == plen(mSt) - 1);
      nx = mSt;
      case (mSt)
        0: if (expd) nx = (mKind == 0) ? 3 : 1;
        1: if (expd) nx = (mKind == 1) ? 3 : 2;
        2: if (expd) nx = mBist ? 4 : 3;
        4: if (bistDone || expd) nx = 3;
        3: if (expd) nx = 5;
        5: if (filt == 1) nx = 6;
        default: ;
      endcase
      if (newS) nx = 0;
      if (newS) mErr = 0;
      else if (mSt == 4 && expd && !bistDone) mErr = 1;
      if (newS) begin
        mKind = req;
        mBist = (bistEn && req >= 2) ? 1 : 0;
      end
      restart = newS || (nx != mSt);
      mCnt = restart ? 0 : mCnt + 1;
      mFresh = restart ? 1 : 0;
      mSt = nx;
      if (s2 == filt) streak = 0;
      else begin
        streak++;
        if (streak >= FC) begin
          filt = s2;
          streak = 0;
        end
      end
      s2 = s1;
      s1 = pinIn ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(pinDriveLow == ((mKind != 0) && (mSt <= 4)), "R7 model pinDriveLow",
            int'(pinDriveLow), int'((mKind != 0) && (mSt <= 4)));
      check(int'(phase) == mSt, "R2 model phase", int'(phase), mSt);
      check(bistStart == ((mSt == 4) && (mFresh == 1)), "R3 model bistStart",
            int'(bistStart), int'((mSt == 4) && (mFresh == 1)));
      check(runMode == (mSt == 6), "R9 model runMode", int'(runMode), int'(mSt == 6));
      check(int'(bistErr) == mErr, "R4 model bistErr", int'(bistErr), mErr);
    end
  end

  // ---------------- helpers ----------------
  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic pulse(bit d, bit e, bit fl, bit fs);
    trigDestr = d; trigExt = e; trigFuncLong = fl; trigFuncShort = fs;
    @(negedge clk);
    trigDestr = 0; trigExt = 0; trigFuncLong = 0; trigFuncShort = 0;
  endtask

  task automatic measure(int code, int exp, string tag);
    int n = 0;
    while (int'(phase) != code) @(negedge clk);
    while (int'(phase) == code) begin
      n++;
      @(negedge clk);
    end
    check(n == exp, tag, n, exp);
  endtask

  task automatic runSeq(output bit [7:0] seen, output int drv);
    seen = '0;
    drv = 0;
    do begin
      seen[phase] = 1'b1;
      if (pinDriveLow) drv++;
      @(negedge clk);
    end while (!runMode);
  endtask

  task automatic waitRun();
    while (!runMode) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(negedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  // ---------------- scenarios ----------------
  initial begin
    bit [7:0] seen;
    int drv, n;
    repeat (3) @(negedge clk);
    check(phase == 3'd0, "R1 reset phase", int'(phase), 0);
    check(pinDriveLow == 1'b1, "R1 reset pinDriveLow", int'(pinDriveLow), 1);
    check(runMode == 1'b0, "R1 reset runMode", int'(runMode), 0);
    check(bistStart == 1'b0, "R1 reset bistStart", int'(bistStart), 0);
    check(bistErr == 1'b0, "R1 reset bistErr", int'(bistErr), 0);
    rstN = 1'b1;

    // Power-on destructive sequence, no self-test
    measure(1, P1, "R2 phase1 length");
    measure(2, P2, "R2 phase2 length");
    measure(3, P3, "R2 phase3 length");
    measure(5, FC + 3, "R8 release latency");
    check(runMode == 1'b1, "R9 run entered", int'(runMode), 1);
    repeat (10) @(negedge clk);
    check(runMode == 1'b1, "R9 run held", int'(runMode), 1);

    // Destructive with self-test, done arrives in 4th cycle
    bistEn = 1; pulse(1, 0, 0, 0); bistEn = 0;
    while (!bistStart) @(negedge clk);
    check(phase == 3'd4, "R3 start in self-test", int'(phase), 4);
    repeat (3) @(negedge clk);
    check(phase == 3'd4, "R3 still in self-test", int'(phase), 4);
    check(bistStart == 1'b0, "R3 start is one cycle", int'(bistStart), 0);
    bistDone = 1; @(negedge clk); bistDone = 0;
    check(phase == 3'd3, "R3 done ends self-test", int'(phase), 3);
    check(bistErr == 1'b0, "R4 no error after done", int'(bistErr), 0);
    waitRun();

    // External with self-test, timeout
    bistEn = 1; pulse(0, 1, 0, 0); bistEn = 0;
    while (!bistStart) @(negedge clk);
    n = 0;
    while (phase == 3'd4) begin
      n++;
      @(negedge clk);
    end
    check(n == BT, "R4 timeout length", n, BT);
    check(bistErr == 1'b1, "R4 timeout error", int'(bistErr), 1);
    waitRun();
    check(bistErr == 1'b1, "R4 error sticky", int'(bistErr), 1);

    // Functional long
    pulse(0, 0, 1, 0);
    check(bistErr == 1'b0, "R4 error cleared", int'(bistErr), 0);
    runSeq(seen, drv);
    check(seen[2] == 1'b0, "R5 no phase2", int'(seen[2]), 0);
    check(seen[4] == 1'b0, "R5 no self-test", int'(seen[4]), 0);
    check(seen[1] == 1'b1, "R5 phase1 visited", int'(seen[1]), 1);
    check(drv == P0 + P1 + P3, "R7 drive cycles", drv, P0 + P1 + P3);

    // Functional short
    pulse(0, 0, 0, 1);
    runSeq(seen, drv);
    check(drv == 0, "R6 pin never driven", drv, 0);
    check(seen[1] == 1'b0 && seen[2] == 1'b0, "R6 phases skipped", int'(seen[1] | seen[2]), 0);
    check(seen[3] == 1'b1, "R6 phase3 visited", int'(seen[3]), 1);

    // Simultaneous requests
    bistEn = 1; pulse(0, 1, 1, 1); bistEn = 0;
    runSeq(seen, drv);
    check(seen[2] == 1'b1 && seen[4] == 1'b1, "R10 external wins",
          int'(seen[2] & seen[4]), 1);

    // Mid-sequence preemption
    pulse(0, 0, 1, 0);
    while (phase != 3'd1) @(negedge clk);
    pulse(1, 0, 0, 0);
    check(phase == 3'd0, "R11 higher rank restarts", int'(phase), 0);
    check(pinDriveLow == 1'b1, "R7 driven after restart", int'(pinDriveLow), 1);
    while (phase != 3'd1) @(negedge clk);
    extHold = 1;
    pulse(0, 0, 0, 1);
    check(phase == 3'd1, "R11 lower rank ignored", int'(phase), 1);
    pulse(1, 0, 0, 0);
    check(phase == 3'd1, "R11 equal rank ignored", int'(phase), 1);

    // Stretch by external hold, glitch, release
    while (phase != 3'd5) @(negedge clk);
    repeat (30) @(negedge clk);
    check(phase == 3'd5, "R8 stretched", int'(phase), 5);
    check(runMode == 1'b0, "R8 no run while held", int'(runMode), 0);
    check(pinDriveLow == 1'b0, "R7 released in wait", int'(pinDriveLow), 0);
    extHold = 0;
    repeat (2) @(negedge clk);
    extHold = 1;
    repeat (10) @(negedge clk);
    check(phase == 3'd5, "R8 glitch ignored", int'(phase), 5);
    extHold = 0;
    n = 0;
    while (!runMode) begin
      @(negedge clk);
      n++;
    end
    check(n == FC + 3, "R8 release edges", n, FC + 3);

    repeat (5) @(negedge clk);
    summary();
  end

endmodule